// File: doc/BRIEF.md
# Loss-of-Frame Integrator

This block filters a raw out-of-frame level into a loss-of-frame alarm for a PLCP receive path. An up/down integrating counter advances on a slow timebase tick. While out-of-frame is high, each tick adds one to the count. While in frame, a prescaler thins the ticks so that the count falls at only a fixed fraction of the rise rate. A burst of out-of-frame activity therefore raises the alarm quickly. Clearing the alarm needs a long and mostly clean stretch. Short, repeated bursts build up in the count rather than being forgotten.

A two-bit static select picks one of four PLCP formats. Each format has its own declare threshold and its own decrement ratio. The alarm is declared when the count reaches the threshold and withdrawn when the count falls back to zero. When the alarm rises, a one-cycle request tells the framer to start a new frame search. The tick is supplied from outside; it is a single-cycle enable and its period is set by the parameter `TICK_US`.

Top module: `lof_integrator`

## Requirements
- R1: After reset, `lof_o` and `reframe_o` are 0 and the count is 0.
- R2: Format codes on `fmt_i` are 0 = DS1, 1 = DS3, 2 = E1 and 3 = G.751 E3. The declare threshold in ticks is the hold time divided by `TICK_US`, using 25 ms, 1 ms, 20 ms and 1 ms. With the default of 125 µs this gives 200, 8, 160 and 8 ticks. Starting from a count of 0, `lof_o` rises on the edge that takes in the threshold-th out-of-frame tick, and it has not risen one tick earlier.
- R3: While in frame with a non-zero count, the count drops by one on every ratio-th tick. The ratio is 10 for DS1, 12 for DS3, 10 for E1 and 9 for E3.
- R4: From a saturated count, `lof_o` falls on the edge that takes in the (threshold × ratio)-th in-frame tick. With the defaults this is 2000, 96, 1600 and 72 ticks, which is 250 ms, 12 ms, 200 ms and 9 ms.
- R5: In-frame ticks do not reset the count. Out-of-frame bursts separated by short in-frame gaps add up and can declare the alarm.
- R6: The count never exceeds the threshold and never goes below zero. Further out-of-frame ticks after declaration do not lengthen the removal time.
- R7: `reframe_o` is high for exactly the one cycle in which `lof_o` rises, and is 0 at all other times.
- R8: A cycle with `tick_i` low changes neither the count, the prescaler nor `lof_o`.
- R9: A change of `fmt_i` clears the count, the prescaler and `lof_o` on the next edge, without a reframe request.
- R10: An out-of-frame tick restarts the prescaler. The next decrement then needs a full ratio of in-frame ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase enable |
| oof_i | input | 1 | Out-of-frame level from the framer |
| fmt_i | input | 2 | PLCP format select (0 DS1, 1 DS3, 2 E1, 3 E3) |
| lof_o | output | 1 | Filtered loss-of-frame alarm |
| reframe_o | output | 1 | One-cycle reframe request on alarm rise |

## Verification
The checker verifies the following on every cycle:
- the count stays within range;
- state holds still without a tick;
- the alarm rises only at the threshold and falls only at zero;
- the reframe pulse lines up with the alarm rise;
- a format change clears everything.

Only the bench scenarios can show the absolute timing. This covers the exact declare and removal tick counts for each format, how gapped bursts accumulate, and the prescaler restart. The bench checks these against a reference model built from the requirements.

// File: rtl/lof_pkg.sv
package lof_pkg;
  typedef enum logic [1:0] {
    FMT_DS1 = 2'd0,
    FMT_DS3 = 2'd1,
    FMT_E1  = 2'd2,
    FMT_E3  = 2'd3
  } plcp_fmt_e;

  localparam int NUM_FMT = 4;

  function automatic int us_to_ticks(input int hold_us, input int tick_us);
    return (hold_us + tick_us - 1) / tick_us;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/lof_fmt_table.sv
module lof_fmt_table
  import lof_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int RAT_W = 4,
  parameter int THR_DS1 = 200,
  parameter int THR_DS3 = 8,
  parameter int THR_E1  = 160,
  parameter int THR_E3  = 8,
  parameter int RAT_DS1 = 10,
  parameter int RAT_DS3 = 12,
  parameter int RAT_E1  = 10,
  parameter int RAT_E3  = 9
) (
  input  logic [1:0]       fmt_i,
  output logic [CNT_W-1:0] thr_o,
  output logic [RAT_W-1:0] ratio_m1_o
);
  logic [CNT_W-1:0] thr_tab   [NUM_FMT];
  logic [RAT_W-1:0] ratio_tab [NUM_FMT];

  function automatic int pick(input int idx, input int a, input int b, input int c, input int d);
    case (idx)
      0:       return a;
      1:       return b;
      2:       return c;
      default: return d;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_tab
    localparam int THR = pick(g, THR_DS1, THR_DS3, THR_E1, THR_E3);
    localparam int RAT = pick(g, RAT_DS1, RAT_DS3, RAT_E1, RAT_E3);
    assign thr_tab[g]   = CNT_W'(THR);
    assign ratio_tab[g] = RAT_W'(RAT - 1);
  end

  assign thr_o      = thr_tab[fmt_i];
  assign ratio_m1_o = ratio_tab[fmt_i];
endmodule

// File: rtl/lof_prescaler.sv
module lof_prescaler #(
  parameter int RAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [RAT_W-1:0] ratio_m1_i,
  output logic             step_o
);
  logic [RAT_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = (pre_q >= ratio_m1_i);
  assign step_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (clear_i)  pre_q <= '0;
    else if (run_i)    pre_q <= wrap ? '0 : pre_q + RAT_W'(1);
  end
endmodule

// File: rtl/lof_updown_counter.sv
module lof_updown_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_top, at_zero;

  assign at_top  = (cnt_q >= thr_i);
  assign at_zero = (cnt_q == '0);
  // next state reaches threshold / zero this edge
  assign hit_o   = inc_i && (cnt_q == thr_i - CNT_W'(1));
  assign empty_o = dec_i && (cnt_q == CNT_W'(1));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (inc_i && !at_top)    cnt_q <= cnt_q + CNT_W'(1);
    else if (dec_i && !at_zero)   cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/lof_alarm.sv
module lof_alarm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  input  logic drop_i,
  output logic lof_o,
  output logic reframe_o
);
  logic lof_q, rf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lof_q <= 1'b0;
      rf_q  <= 1'b0;
    end else if (clear_i) begin
      lof_q <= 1'b0;
      rf_q  <= 1'b0;
    end else begin
      rf_q <= set_i && !lof_q;
      if (set_i)       lof_q <= 1'b1;
      else if (drop_i) lof_q <= 1'b0;
    end
  end

  assign lof_o     = lof_q;
  assign reframe_o = rf_q;
endmodule

// File: rtl/lof_integrator.sv
module lof_integrator
  import lof_pkg::*;
#(
  parameter int TICK_US    = 125,
  parameter int SET_US_DS1 = 25000,
  parameter int SET_US_DS3 = 1000,
  parameter int SET_US_E1  = 20000,
  parameter int SET_US_E3  = 1000,
  parameter int RAT_DS1    = 10,
  parameter int RAT_DS3    = 12,
  parameter int RAT_E1     = 10,
  parameter int RAT_E3     = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       oof_i,
  input  logic [1:0] fmt_i,
  output logic       lof_o,
  output logic       reframe_o
);
  localparam int THR_DS1 = us_to_ticks(SET_US_DS1, TICK_US);
  localparam int THR_DS3 = us_to_ticks(SET_US_DS3, TICK_US);
  localparam int THR_E1  = us_to_ticks(SET_US_E1, TICK_US);
  localparam int THR_E3  = us_to_ticks(SET_US_E3, TICK_US);
  localparam int THR_MAX = max4(THR_DS1, THR_DS3, THR_E1, THR_E3);
  localparam int RAT_MAX = max4(RAT_DS1, RAT_DS3, RAT_E1, RAT_E3);
  localparam int CNT_W   = $clog2(THR_MAX + 1);
  localparam int RAT_W   = (RAT_MAX > 2) ? $clog2(RAT_MAX) : 1;

  logic [1:0]       fmt_q;
  logic             fmt_chg;
  logic [CNT_W-1:0] thr, cnt;
  logic [RAT_W-1:0] ratio_m1;
  logic             up, run_dn, pre_clr, step, hit, empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt_q <= FMT_DS1;
    else         fmt_q <= fmt_i;
  end

  assign fmt_chg = (fmt_i != fmt_q);
  assign up      = !fmt_chg && tick_i && oof_i;
  assign run_dn  = !fmt_chg && tick_i && !oof_i && (cnt != '0);
  // prescaler restarts on any OOF tick or when nothing is left to drain
  assign pre_clr = fmt_chg || up || (tick_i && !oof_i && (cnt == '0));

  lof_fmt_table #(
    .CNT_W(CNT_W), .RAT_W(RAT_W),
    .THR_DS1(THR_DS1), .THR_DS3(THR_DS3), .THR_E1(THR_E1), .THR_E3(THR_E3),
    .RAT_DS1(RAT_DS1), .RAT_DS3(RAT_DS3), .RAT_E1(RAT_E1), .RAT_E3(RAT_E3)
  ) u_tab (
    .fmt_i      (fmt_q),
    .thr_o      (thr),
    .ratio_m1_o (ratio_m1)
  );

  lof_prescaler #(.RAT_W(RAT_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (pre_clr),
    .run_i      (run_dn),
    .ratio_m1_i (ratio_m1),
    .step_o     (step)
  );

  lof_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (fmt_chg),
    .inc_i   (up),
    .dec_i   (step),
    .thr_i   (thr),
    .cnt_o   (cnt),
    .hit_o   (hit),
    .empty_o (empty)
  );

  lof_alarm u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (fmt_chg),
    .set_i     (hit),
    .drop_i    (empty),
    .lof_o     (lof_o),
    .reframe_o (reframe_o)
  );
endmodule

// File: rtl/lof_integrator_chk.sv
module lof_integrator_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       fmt_i,
  input logic [1:0]       fmt_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] thr,
  input logic             lof_o,
  input logic             reframe_o
);
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= thr);

  a_r2_rise_at_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lof_o) |-> (cnt == thr));

  a_r4_fall_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lof_o) && (fmt_i == $past(fmt_i)) |-> (cnt == '0));

  a_r7_pulse_with_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reframe_o |-> $rose(lof_o));

  a_r7_rise_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lof_o) |-> reframe_o);

  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reframe_o |=> !reframe_o);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && fmt_i == fmt_q) |=> ($stable(cnt) && $stable(lof_o)));

  a_r9_fmt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i != fmt_q) |=> (cnt == '0 && !lof_o && !reframe_o));
endmodule

bind lof_integrator lof_integrator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .fmt_i     (fmt_i),
  .fmt_q     (fmt_q),
  .cnt       (cnt),
  .thr       (thr),
  .lof_o     (lof_o),
  .reframe_o (reframe_o)
);

// File: tb/lof_integrator_tb.sv
module lof_integrator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, oof = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic lof, rf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_fmt = 0, m_cnt = 0, m_pre = 0;
  bit m_lof = 1'b0, m_rf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lof_integrator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .oof_i(oof),
    .fmt_i(fmt), .lof_o(lof), .reframe_o(rf)
  );

  function automatic int thr_of(input int f);
    case (f) 0: return 200; 1: return 8; 2: return 160; default: return 8; endcase
  endfunction

  function automatic int rat_of(input int f);
    case (f) 0: return 10; 1: return 12; 2: return 10; default: return 9; endcase
  endfunction

  task automatic model_edge(input bit t, input bit o, input int f);
    bit old = m_lof;
    m_rf = 1'b0;
    if (f != m_fmt) begin
      m_fmt = f; m_cnt = 0; m_pre = 0; m_lof = 1'b0;
    end else if (t) begin
      if (o) begin
        m_pre = 0;
        if (m_cnt < thr_of(f)) m_cnt++;
      end else if (m_cnt > 0) begin
        if (m_pre == rat_of(f) - 1) begin m_pre = 0; m_cnt--; end
        else m_pre++;
      end else m_pre = 0;
      if (m_cnt == thr_of(f)) begin m_lof = 1'b1; m_rf = !old; end
      if (m_cnt == 0) m_lof = 1'b0;
    end
  endtask

  task automatic check(input string tag, input bit act_l, input bit act_r,
                       input bit exp_l, input bit exp_r);
    n_chk++;
    if (act_l !== exp_l || act_r !== exp_r) begin
      n_fail++;
      $display("FAIL %s lof/reframe actual=%b%b expected=%b%b at %0t",
               tag, act_l, act_r, exp_l, exp_r, $time);
    end
  endtask

  task automatic step(input string tag, input bit t, input bit o, input int f);
    @(negedge clk);
    tick = t; oof = o; fmt = 2'(f);
    model_edge(t, o, f);
    @(posedge clk); #1;
    check(tag, lof, rf, m_lof, m_rf);
  endtask

  task automatic steps(input string tag, input int n, input bit o, input int f);
    for (int i = 0; i < n; i++) step(tag, 1'b1, o, f);
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYC);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int nb;
    #(CLK_PERIOD*3);
    #1 check("R1", lof, rf, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R7: declare exactly at threshold, each format
    for (int f = 0; f < 4; f++) begin
      step("R9", 1'b0, 1'b0, f);
      steps("R2", thr_of(f) - 1, 1'b1, f);
      check("R2 not before threshold", lof, rf, 1'b0, 1'b0);
      step("R7", 1'b1, 1'b1, f);
      check("R2 declare", lof, rf, 1'b1, 1'b1);
      step("R7 single", 1'b0, 1'b1, f);
      check("R7 pulse gone", lof, rf, 1'b1, 1'b0);
      // R6: extra OOF does not extend removal
      steps("R6", 5, 1'b1, f);
      // R8: idle cycles change nothing
      for (int i = 0; i < 7; i++) step("R8", 1'b0, 1'b0, f);
      // R3/R4: removal after thr*ratio in-frame ticks
      steps("R4", thr_of(f) * rat_of(f) - 1, 1'b0, f);
      check("R4 still set", lof, rf, 1'b1, 1'b0);
      step("R4", 1'b1, 1'b0, f);
      check("R4 removed", lof, rf, 1'b0, 1'b0);
    end

    // R5: gapped bursts accumulate (DS3: 8 up, ratio 12)
    step("R9", 1'b0, 1'b0, 1);
    for (int b = 0; b < 7; b++) begin
      steps("R5", 2, 1'b1, 1);
      steps("R5", 11, 1'b0, 1);
    end
    check("R5 accumulated", lof, rf, 1'b1, 1'b0);

    // R10: OOF tick restarts prescaler
    step("R9", 1'b0, 1'b0, 3);
    steps("R10", 1, 1'b1, 3);
    steps("R10", 8, 1'b0, 3);
    steps("R10", 1, 1'b1, 3);
    steps("R10", 8, 1'b0, 3);
    step("R10", 1'b1, 1'b1, 3);

    // R9: format change while declared
    steps("R9", 8, 1'b1, 3);
    check("R9 pre", lof, rf, 1'b1, 1'b0);
    step("R9", 1'b1, 1'b1, 1);
    check("R9 cleared", lof, rf, 1'b0, 1'b0);

    // random mix against the model
    void'($urandom(32'h1F0F));
    for (int s = 0; s < 400; s++) begin
      int f = m_fmt;
      if ($urandom_range(0, 19) == 0) f = $urandom_range(0, 3);
      nb = $urandom_range(1, 14);
      for (int i = 0; i < nb; i++)
        step("R3 R5 random", ($urandom_range(0, 3) != 0), 1'b1, f);
      nb = $urandom_range(1, 60);
      for (int i = 0; i < nb; i++)
        step("R3 R4 random", ($urandom_range(0, 3) != 0), ($urandom_range(0, 15) == 0), f);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule